// File: doc/BRIEF.md
# Counter CSR unit

This unit keeps the two free-running 64-bit counters that a small multi-cycle RV32 core exposes to software as read-only CSRs. One counter advances on every clock and also stands in as the wall-clock time source. The other counts retired instructions. The core's control FSM drives a one-cycle retire pulse on the cycle it moves into its writeback state. Trapped, halted and in-flight multi-cycle instructions never produce that pulse, so they add nothing.

The core presents a 12-bit CSR address, a valid strobe and a write-intent bit. The unit decodes the address to one of five selections and answers in the same cycle with the low or high 32-bit half of the chosen counter. The selections are SEL_CYC_LO, SEL_CYC_HI, SEL_RET_LO, SEL_RET_HI and SEL_NONE, the last for a miss. It also raises an illegal flag when software tries to modify a counter. The core's trap logic uses that flag. The reset value of each counter is a parameter. Both default to zero.

Top module: `csr_counter_unit`

## Requirements
- R1: Low halves are read as follows. Address 0xC00 returns bits 31:0 of the cycle counter, and 0xC02 returns bits 31:0 of the retire counter.
- R2: High halves are read as follows. Address 0xC80 returns bits 63:32 of the cycle counter, and 0xC82 returns bits 63:32 of the retire counter.
- R3: While reset is low, the cycle counter grows by exactly one on every rising clock edge.
- R4: Addresses 0xC01 and 0xC81 return the same values as 0xC00 and 0xC80, because the time source is the cycle counter.
- R5: The retire counter grows by one on each rising edge at which `retire_i` is 1.
- R6: With `retire_i` at 0, the retire counter holds its value for any number of cycles while the cycle counter keeps advancing. This covers halt, trap and multi-cycle stall periods.
- R7: `csr_hit_o` is 1 only for the six addresses 0xC00, 0xC01, 0xC02, 0xC80, 0xC81 and 0xC82. For any other address, `csr_rdata_o` is 0 and `csr_illegal_o` is 0.
- R8: `csr_illegal_o` is 1 when `csr_valid_i`, `csr_wr_intent_i` and a hit are all 1 together.
- R9: An access with `csr_wr_intent_i` at 0 never raises `csr_illegal_o`. This holds for the high-half addresses too.
- R10: Synchronous reset loads the cycle counter with CYC_RST_VAL and the retire counter with RET_RST_VAL. Both default to 0. A carry out of bit 31 reaches bit 32 on the same edge.
- R11: Read data is combinational. A read in a given cycle returns the counter value as of the start of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One-cycle pulse on entry to writeback |
| csr_valid_i | input | 1 | CSR access in progress |
| csr_addr_i | input | 12 | CSR address |
| csr_wr_intent_i | input | 1 | Access would modify bits (CSRRW, or CSRRS/CSRRC with a nonzero operand) |
| csr_hit_o | output | 1 | Address is one of the six counter CSRs |
| csr_rdata_o | output | 32 | Selected counter half, 0 on a miss |
| csr_illegal_o | output | 1 | Write attempt to a counter CSR |

## Verification
A vector table first steps through all six counter addresses with write intent cleared, so that each low and high half is compared against a counter model kept in the bench. The table then sends writes to hit addresses, which separates legal reads from illegal writes. Writes and reads to neighbouring addresses follow; these show that the decoder neither hits nor flags outside its range. Directed phases then cover three cases. A long stretch without retire pulses separates a stalled retire counter from a free-running cycle counter. Pulses spaced several cycles apart mimic multi-cycle instructions. A second instance preset just below 2^32 shows the low-to-high carry landing on the right edge.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    localparam int CSR_AW = 12;
    localparam int XLEN   = 32;
    localparam int CNT_W  = 64;

    localparam logic [CSR_AW-1:0] A_CYC_LO  = 12'hC00;
    localparam logic [CSR_AW-1:0] A_TIME_LO = 12'hC01;
    localparam logic [CSR_AW-1:0] A_RET_LO  = 12'hC02;
    localparam logic [CSR_AW-1:0] A_CYC_HI  = 12'hC80;
    localparam logic [CSR_AW-1:0] A_TIME_HI = 12'hC81;
    localparam logic [CSR_AW-1:0] A_RET_HI  = 12'hC82;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CYC_LO,
        SEL_CYC_HI,
        SEL_RET_LO,
        SEL_RET_HI
    } ctr_sel_e;
endpackage

// File: rtl/ctr_count64.sv
module ctr_count64 #(
    parameter int             W       = 64,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    output logic [W-1:0] value_o
);
    localparam int HW = W / 2;
    localparam logic [HW-1:0]     LO_ONE = 1;
    localparam logic [W-HW-1:0]   HI_ONE = 1;

    logic [HW-1:0]   lo_q;
    logic [W-HW-1:0] hi_q;
    logic            lo_wrap;

    // carry into the upper half happens on the same edge as the low wrap
    assign lo_wrap = &lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= RST_VAL[HW-1:0];
            hi_q <= RST_VAL[W-1:HW];
        end else if (inc_i) begin
            lo_q <= lo_q + LO_ONE;
            if (lo_wrap) begin
                hi_q <= hi_q + HI_ONE;
            end
        end
    end

    assign value_o = {hi_q, lo_q};
endmodule

// File: rtl/ctr_addr_decode.sv
module ctr_addr_decode
    import ctr_pkg::*;
(
    input  logic [CSR_AW-1:0] addr_i,
    output ctr_sel_e          sel_o,
    output logic              hit_o
);
    always_comb begin
        unique case (addr_i)
            A_CYC_LO, A_TIME_LO: sel_o = SEL_CYC_LO;
            A_CYC_HI, A_TIME_HI: sel_o = SEL_CYC_HI;
            A_RET_LO:            sel_o = SEL_RET_LO;
            A_RET_HI:            sel_o = SEL_RET_HI;
            default:             sel_o = SEL_NONE;
        endcase
        hit_o = (sel_o != SEL_NONE);
    end
endmodule

// File: rtl/csr_counter_unit.sv
module csr_counter_unit
    import ctr_pkg::*;
#(
    parameter logic [CNT_W-1:0] CYC_RST_VAL = '0,
    parameter logic [CNT_W-1:0] RET_RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              retire_i,
    input  logic              csr_valid_i,
    input  logic [CSR_AW-1:0] csr_addr_i,
    input  logic              csr_wr_intent_i,
    output logic              csr_hit_o,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              csr_illegal_o
);
    logic [CNT_W-1:0] cyc_val;
    logic [CNT_W-1:0] ret_val;
    ctr_sel_e         sel;
    logic             hit;

    ctr_count64 #(.W(CNT_W), .RST_VAL(CYC_RST_VAL)) u_cyc (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (1'b1),
        .value_o (cyc_val)
    );

    ctr_count64 #(.W(CNT_W), .RST_VAL(RET_RST_VAL)) u_ret (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (retire_i),
        .value_o (ret_val)
    );

    ctr_addr_decode u_dec (
        .addr_i (csr_addr_i),
        .sel_o  (sel),
        .hit_o  (hit)
    );

    always_comb begin
        unique case (sel)
            SEL_CYC_LO: csr_rdata_o = cyc_val[XLEN-1:0];
            SEL_CYC_HI: csr_rdata_o = cyc_val[CNT_W-1:XLEN];
            SEL_RET_LO: csr_rdata_o = ret_val[XLEN-1:0];
            SEL_RET_HI: csr_rdata_o = ret_val[CNT_W-1:XLEN];
            default:    csr_rdata_o = '0;
        endcase
    end

    assign csr_hit_o     = hit;
    assign csr_illegal_o = csr_valid_i & csr_wr_intent_i & hit;
endmodule

// File: rtl/csr_counter_chk.sv
module csr_counter_chk (
    input logic        clk,
    input logic        rst,
    input logic        retire,
    input logic        valid,
    input logic [11:0] addr,
    input logic        wr,
    input logic        hit,
    input logic        ill,
    input logic [31:0] rdata,
    input logic [63:0] cyc,
    input logic [63:0] ret
);
    // R3
    cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> cyc == $past(cyc) + 64'd1);

    // R5
    retire_step_chk: assert property (@(posedge clk) disable iff (rst)
        retire |=> ret == $past(ret) + 64'd1);

    // R6
    retire_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !retire |=> ret == $past(ret));

    // R4
    time_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == 12'hC01) |-> rdata == cyc[31:0]);

    // R7
    hit_range_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (addr == 12'hC00 || addr == 12'hC01 || addr == 12'hC02 ||
                 addr == 12'hC80 || addr == 12'hC81 || addr == 12'hC82));

    // R8
    illegal_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ill |-> (valid && wr && hit));

    // R9
    read_legal_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |-> !ill);
endmodule

bind csr_counter_unit csr_counter_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .retire (retire_i),
    .valid  (csr_valid_i),
    .addr   (csr_addr_i),
    .wr     (csr_wr_intent_i),
    .hit    (csr_hit_o),
    .ill    (csr_illegal_o),
    .rdata  (csr_rdata_o),
    .cyc    (cyc_val),
    .ret    (ret_val)
);

// File: tb/csr_counter_unit_bench.sv
`timescale 1ns/100ps
module csr_counter_unit_bench;
    localparam logic [63:0] PRE_CYC = 64'h0000_0000_FFFF_FFF0;
    localparam logic [63:0] PRE_RET = 64'h0000_0000_FFFF_FFFE;
    localparam int NVEC = 12;
    // {addr[11:0], wr, retire, exp_hit, exp_ill, kind[2:0]}
    // kind: 0 none, 1 cycle lo, 2 cycle hi, 3 retire lo, 4 retire hi
    localparam logic [18:0] VEC [NVEC] = '{
        {12'hC00, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1},
        {12'hC01, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1},
        {12'hC02, 1'b0, 1'b1, 1'b1, 1'b0, 3'd3},
        {12'hC80, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2},
        {12'hC81, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2},
        {12'hC82, 1'b0, 1'b0, 1'b1, 1'b0, 3'd4},
        {12'hC00, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1},
        {12'hC82, 1'b1, 1'b0, 1'b1, 1'b1, 3'd4},
        {12'hC03, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
        {12'hC83, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
        {12'hB00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
        {12'h400, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        retire = 1'b0;
    logic        valid = 1'b0;
    logic [11:0] addr = 12'h000;
    logic        wr = 1'b0;
    logic        hit, ill, hit2, ill2;
    logic [31:0] rdata, rdata2;

    logic [63:0] m_cyc, m_ret, p_cyc, p_ret;
    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    csr_counter_unit u_csr_counter_unit (
        .clk(clk), .rst(rst), .retire_i(retire), .csr_valid_i(valid),
        .csr_addr_i(addr), .csr_wr_intent_i(wr),
        .csr_hit_o(hit), .csr_rdata_o(rdata), .csr_illegal_o(ill)
    );

    csr_counter_unit #(.CYC_RST_VAL(PRE_CYC), .RET_RST_VAL(PRE_RET)) u_csr_counter_unit_pre (
        .clk(clk), .rst(rst), .retire_i(retire), .csr_valid_i(valid),
        .csr_addr_i(addr), .csr_wr_intent_i(wr),
        .csr_hit_o(hit2), .csr_rdata_o(rdata2), .csr_illegal_o(ill2)
    );

    // counter model built from R3, R5, R10
    always @(posedge clk) begin
        if (rst) begin
            m_cyc <= 64'd0;  m_ret <= 64'd0;
            p_cyc <= PRE_CYC; p_ret <= PRE_RET;
        end else begin
            m_cyc <= m_cyc + 64'd1;
            p_cyc <= p_cyc + 64'd1;
            if (retire) begin
                m_ret <= m_ret + 64'd1;
                p_ret <= p_ret + 64'd1;
            end
        end
    end

    function automatic logic [31:0] pick(input logic [2:0] kind,
                                         input logic [63:0] c, input logic [63:0] r);
        case (kind)
            3'd1: pick = c[31:0];
            3'd2: pick = c[63:32];
            3'd3: pick = r[31:0];
            3'd4: pick = r[63:32];
            default: pick = 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        addr = a; wr = 1'b0; valid = 1'b1;
        #1;
    endtask

    initial begin
        logic [31:0] v0;
        logic [31:0] r0;
        // reset state, R10
        repeat (3) @(posedge clk);
        rd(12'hC00); check("R10 cycle lo at reset", rdata, 32'd0);
        rd(12'hC82); check("R10 retire hi at reset", rdata, 32'd0);
        rd(12'hC80); check("R10 preset cycle hi", rdata2, 32'd0);
        rd(12'hC00); check("R10 preset cycle lo", rdata2, 32'hFFFF_FFF0);
        @(negedge clk); rst = 1'b0;

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [18:0] v;
            v = VEC[i];
            @(negedge clk);
            addr = v[18:7]; wr = v[6]; retire = v[5]; valid = 1'b1;
            #1;
            check("R7 hit", {31'd0, hit}, {31'd0, v[4]});
            if (v[6]) check("R8 illegal", {31'd0, ill}, {31'd0, v[3]});
            else      check("R9 illegal on read", {31'd0, ill}, {31'd0, v[3]});
            check("R1/R2/R4/R11 rdata", rdata, pick(v[2:0], m_cyc, m_ret));
        end
        @(negedge clk); retire = 1'b0;

        // valid low with write intent: no flag (R8)
        valid = 1'b0; wr = 1'b1; addr = 12'hC00; #1;
        check("R8 no flag without valid", {31'd0, ill}, 32'd0);

        // R3: five clocks give plus five
        rd(12'hC00); v0 = rdata;
        repeat (5) @(negedge clk);
        #1;
        check("R3 cycle step", rdata, v0 + 32'd5);

        // R6: long stretch with no retire
        rd(12'hC02); r0 = rdata; v0 = 32'd0;
        rd(12'hC01); v0 = rdata;
        repeat (20) @(negedge clk);
        addr = 12'hC02; #1;
        check("R6 retire held", rdata, r0);
        addr = 12'hC01; #1;
        check("R6 cycle moved", rdata, v0 + 32'd20);
        check("R4 time equals cycle", rdata, m_cyc[31:0]);

        // R5: spaced pulses as multi-cycle instructions
        addr = 12'hC02; #1; r0 = rdata;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); retire = 1'b1;
            @(negedge clk); retire = 1'b0;
            repeat (3) @(negedge clk);
        end
        #1;
        check("R5 retire count", rdata, r0 + 32'd5);

        // R10 carry on preset instance
        rd(12'hC80); check("R10 cycle carry hi", rdata2, 32'd1);
        check("R10 cycle hi model", rdata2, p_cyc[63:32]);
        rd(12'hC00); check("R10 cycle lo model", rdata2, p_cyc[31:0]);
        rd(12'hC82); check("R10 retire carry hi", rdata2, 32'd1);
        rd(12'hC02); check("R10 retire lo", rdata2, 32'd5);
        rd(12'hC81); check("R4 timeh equals cycleh", rdata2, 32'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule